// File: doc/BRIEF.md
# Dual-Array Access Mode Arbiter

This block sits in front of two memory arrays that share one address bus, one data bus, one output-enable strobe and one write-enable strobe. Each array has its own active-low chip select: one array holds program code, the other holds data. The block brings the four asynchronous strobes into the system clock domain and removes short noise pulses. It then decodes each settled strobe combination into exactly one access mode, which it reports as a one-hot vector.

Two busy inputs tell the block which array is in an internal write cycle. From them it decides how a read is handled. A read is served normally, becomes a status poll, or is refused. The program array stays readable while the data array is writing, but the data array may not be read while the program array is writing. The block drives the enable for the shared data bus. When both chip selects are active together, it raises a one-cycle illegal-state pulse and blocks every access.

Top module: `dual_array_arbiter`

## Requirements
- R1: Reset state: `mode_vec` is 8'h10 (standby), `rd_kind` is 0, `bus_oe` is 0 and `illegal_pulse` is 0.
- R2: Mode bits are fixed. Bit 0 is read program, bit 1 read data, bit 2 load program, bit 3 load data, bit 4 standby, bit 5 output disabled, bit 6 inhibit and bit 7 illegal. Exactly one bit is set at all times.
- R3: One chip select low, the other high, `oe_n` low and `we_n` high decodes as a read of the selected array.
- R4: One chip select low, the other high, `we_n` low and `oe_n` high decodes as a write-load of the selected array.
- R5: With one chip select low, `oe_n` and `we_n` both low decode as inhibit, and both high decode as output disabled. Neither case reports a load.
- R6: Both chip selects high decode as standby, and `bus_oe` is 0.
- R7: Both chip selects low decode as illegal. `rd_kind` is then 0 and `bus_oe` is 0, and `illegal_pulse` is high for exactly one cycle on entry to that state.
- R8: A read of the program array while `prog_busy` is low gives `rd_kind` 1 (normal data) with `bus_oe` 1, whatever the value of `data_busy`.
- R9: A read of the program array while `prog_busy` is high gives `rd_kind` 2 (status poll) with `bus_oe` 1.
- R10: A read of the data array while `prog_busy` is high gives `rd_kind` 3 (refused) with `bus_oe` 0. While only `data_busy` is high, the same read gives `rd_kind` 2 with `bus_oe` 1. With neither busy input high, it gives `rd_kind` 1 with `bus_oe` 1.
- R11: A strobe level held for fewer than FILT_CYCLES clock cycles does not change the decoded mode. A level held longer reaches `mode_vec` exactly SYNC_STAGES+FILT_CYCLES+1 clock edges after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_prog_n | input | 1 | Program array chip select, active low, asynchronous |
| cs_data_n | input | 1 | Data array chip select, active low, asynchronous |
| oe_n | input | 1 | Shared output enable, active low, asynchronous |
| we_n | input | 1 | Shared write enable, active low, asynchronous |
| prog_busy | input | 1 | Program array is in its internal write cycle |
| data_busy | input | 1 | Data array is in its internal write cycle |
| mode_vec | output | 8 | One-hot decoded access mode |
| rd_kind | output | 2 | Read disposition: 0 none, 1 data, 2 poll, 3 refused |
| bus_oe | output | 1 | Drive enable for the shared data bus |
| illegal_pulse | output | 1 | One-cycle pulse on entry to the both-selected state |

## Verification
The hardest case to reach from the ports is a noise pulse that is exactly one cycle shorter than the filter threshold. A random mix of held strobe levels never produces one. The stimulus therefore drives write-enable low for FILT_CYCLES-1 cycles and then for FILT_CYCLES cycles, with the program array already selected. A monitor watches every cycle for a load-program mode bit: the first pulse must produce none and the second must produce one. Random held patterns with random busy levels then cover the read disposition table, including the concurrent case where the data array is busy.

// File: rtl/dual_arb_pkg.sv
package dual_arb_pkg;
   localparam int NUM_MODES = 8;
   localparam int M_RD_PROG = 0;
   localparam int M_RD_DATA = 1;
   localparam int M_LD_PROG = 2;
   localparam int M_LD_DATA = 3;
   localparam int M_STANDBY = 4;
   localparam int M_OUT_DIS = 5;
   localparam int M_INHIBIT = 6;
   localparam int M_ILLEGAL = 7;

   typedef enum logic [1:0] {
      RD_NONE   = 2'd0,
      RD_DATA   = 2'd1,
      RD_POLL   = 2'd2,
      RD_REFUSE = 2'd3
   } rd_kind_e;

   typedef struct packed {
      logic cs_prog_n;
      logic cs_data_n;
      logic oe_n;
      logic we_n;
   } strobes_t;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] stage_q [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '1;
               else        stage_q[s] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '1;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/strobe_filter.sv
module strobe_filter #(
   parameter int FILT_CYCLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (FILT_CYCLES <= 1) begin : g_direct
         logic lvl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q <= 1'b1;
            else        lvl_q <= din;
         end
         assign dout = lvl_q;
      end else begin : g_count
         localparam int CNT_W = $clog2(FILT_CYCLES + 1);
         localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYCLES - 1);
         logic             lvl_q;
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lvl_q <= 1'b1;
               cnt_q <= '0;
            end else if (din != lvl_q) begin
               if (cnt_q == CNT_LAST) begin
                  lvl_q <= din;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end else begin
               cnt_q <= '0;
            end
         end
         assign dout = lvl_q;
      end
   endgenerate
endmodule

// File: rtl/access_decode.sv
module access_decode
   import dual_arb_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  strobes_t             stb,
   input  logic                 prog_busy,
   input  logic                 data_busy,
   output logic [NUM_MODES-1:0] mode_q,
   output rd_kind_e             rd_q,
   output logic                 oe_q,
   output logic                 illegal_q
);
   logic [NUM_MODES-1:0] mode_d;
   rd_kind_e             rd_d;
   logic                 one_sel;
   logic                 sel_prog;

   always_comb begin
      mode_d   = '0;
      one_sel  = stb.cs_prog_n ^ stb.cs_data_n;
      sel_prog = !stb.cs_prog_n;
      if (!stb.cs_prog_n && !stb.cs_data_n) begin
         mode_d[M_ILLEGAL] = 1'b1;
      end else if (!one_sel) begin
         mode_d[M_STANDBY] = 1'b1;
      end else begin
         unique case ({stb.oe_n, stb.we_n})
            2'b01:   mode_d[sel_prog ? M_RD_PROG : M_RD_DATA] = 1'b1;
            2'b10:   mode_d[sel_prog ? M_LD_PROG : M_LD_DATA] = 1'b1;
            2'b11:   mode_d[M_OUT_DIS] = 1'b1;
            default: mode_d[M_INHIBIT] = 1'b1;
         endcase
      end
   end

   always_comb begin
      rd_d = RD_NONE;
      if (mode_d[M_RD_PROG]) begin
         rd_d = prog_busy ? RD_POLL : RD_DATA;
      end else if (mode_d[M_RD_DATA]) begin
         if (prog_busy)      rd_d = RD_REFUSE;
         else if (data_busy) rd_d = RD_POLL;
         else                rd_d = RD_DATA;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= NUM_MODES'(1) << M_STANDBY;
         rd_q      <= RD_NONE;
         oe_q      <= 1'b0;
         illegal_q <= 1'b0;
      end else begin
         mode_q    <= mode_d;
         rd_q      <= rd_d;
         oe_q      <= (rd_d == RD_DATA) || (rd_d == RD_POLL);
         illegal_q <= mode_d[M_ILLEGAL] && !mode_q[M_ILLEGAL];
      end
   end
endmodule

// File: rtl/dual_array_arbiter.sv
module dual_array_arbiter
   import dual_arb_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_CYCLES = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_prog_n,
   input  logic       cs_data_n,
   input  logic       oe_n,
   input  logic       we_n,
   input  logic       prog_busy,
   input  logic       data_busy,
   output logic [7:0] mode_vec,
   output logic [1:0] rd_kind,
   output logic       bus_oe,
   output logic       illegal_pulse
);
   localparam int NSTB = $bits(strobes_t);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (FILT_CYCLES < 1) begin : g_bad_filt
         $error("FILT_CYCLES must be at least 1");
      end
   endgenerate

   strobes_t         raw_stb;
   logic [NSTB-1:0]  sync_stb;
   logic [NSTB-1:0]  filt_stb;
   rd_kind_e         rd_int;

   assign raw_stb = '{cs_prog_n: cs_prog_n, cs_data_n: cs_data_n,
                      oe_n: oe_n, we_n: we_n};

   strobe_sync #(.WIDTH(NSTB), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_stb),
      .dout (sync_stb)
   );

   genvar i;
   generate
      for (i = 0; i < NSTB; i++) begin : g_filt
         strobe_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (sync_stb[i]),
            .dout (filt_stb[i])
         );
      end
   endgenerate

   access_decode u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb      (strobes_t'(filt_stb)),
      .prog_busy(prog_busy),
      .data_busy(data_busy),
      .mode_q   (mode_vec),
      .rd_q     (rd_int),
      .oe_q     (bus_oe),
      .illegal_q(illegal_pulse)
   );

   assign rd_kind = rd_int;
endmodule

// File: rtl/dual_array_arbiter_chk.sv
module dual_array_arbiter_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       prog_busy,
   input logic [7:0] mode_vec,
   input logic [1:0] rd_kind,
   input logic       bus_oe,
   input logic       illegal_pulse
);
   AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mode_vec) == 1); // R2
   AST_STANDBY_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      mode_vec[4] |-> !bus_oe); // R6
   AST_ILLEGAL_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      mode_vec[7] |-> (!bus_oe && rd_kind == 2'd0)); // R7
   AST_ILLEGAL_PULSE_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_pulse |-> mode_vec[7]); // R7
   AST_ILLEGAL_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_pulse |=> !illegal_pulse); // R7
   AST_PROG_READ_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_vec[0] && !$past(prog_busy)) |-> (rd_kind == 2'd1 && bus_oe)); // R8
   AST_PROG_READ_POLL: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_vec[0] && $past(prog_busy)) |-> (rd_kind == 2'd2 && bus_oe)); // R9
   AST_DATA_READ_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_vec[1] && $past(prog_busy)) |-> (rd_kind == 2'd3 && !bus_oe)); // R10
endmodule

bind dual_array_arbiter dual_array_arbiter_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .prog_busy    (prog_busy),
   .mode_vec     (mode_vec),
   .rd_kind      (rd_kind),
   .bus_oe       (bus_oe),
   .illegal_pulse(illegal_pulse)
);

// File: tb/dual_array_arbiter_test.sv
module dual_array_arbiter_test;
   localparam int SYNC = 2;
   localparam int FILT = 3;
   localparam int LAT  = SYNC + FILT + 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_prog_n = 1'b1, cs_data_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic       prog_busy = 1'b0, data_busy = 1'b0;
   logic [7:0] mode_vec;
   logic [1:0] rd_kind;
   logic       bus_oe, illegal_pulse;

   int n_chk = 0;
   int n_fail = 0;
   int ld_seen = 0;
   int ill_seen = 0;
   logic mon_on = 1'b0;
   bit   done = 1'b0;

   always #5 clk = ~clk;

   dual_array_arbiter #(.SYNC_STAGES(SYNC), .FILT_CYCLES(FILT)) uut (
      .clk(clk), .rst_n(rst_n), .cs_prog_n(cs_prog_n), .cs_data_n(cs_data_n),
      .oe_n(oe_n), .we_n(we_n), .prog_busy(prog_busy), .data_busy(data_busy),
      .mode_vec(mode_vec), .rd_kind(rd_kind), .bus_oe(bus_oe),
      .illegal_pulse(illegal_pulse)
   );

   always @(negedge clk) if (mon_on) begin
      if (mode_vec[2]) ld_seen++;
      if (illegal_pulse) ill_seen++;
   end

   function automatic logic [7:0] exp_mode(logic cp, logic cd, logic o, logic w);
      if (!cp && !cd) return 8'h80;
      if (cp && cd)   return 8'h10;
      case ({o, w})
         2'b01:   return !cp ? 8'h01 : 8'h02;
         2'b10:   return !cp ? 8'h04 : 8'h08;
         2'b11:   return 8'h20;
         default: return 8'h40;
      endcase
   endfunction

   function automatic logic [1:0] exp_rd(logic [7:0] m, logic pb, logic db);
      if (m == 8'h01) return pb ? 2'd2 : 2'd1;
      if (m == 8'h02) return pb ? 2'd3 : (db ? 2'd2 : 2'd1);
      return 2'd0;
   endfunction

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic apply(logic cp, logic cd, logic o, logic w, logic pb, logic db);
      @(negedge clk);
      cs_prog_n = cp; cs_data_n = cd; oe_n = o; we_n = w;
      prog_busy = pb; data_busy = db;
      repeat (LAT + 3) @(negedge clk);
   endtask

   task automatic check_all(string req);
      logic [7:0] em;
      logic [1:0] er;
      em = exp_mode(cs_prog_n, cs_data_n, oe_n, we_n);
      er = exp_rd(em, prog_busy, data_busy);
      check(mode_vec == em, {req, " mode"}, 32'(mode_vec), 32'(em));
      check(rd_kind == er, {req, " rd_kind"}, 32'(rd_kind), 32'(er));
      check(bus_oe == (er == 2'd1 || er == 2'd2), {req, " bus_oe"},
            32'(bus_oe), 32'(er == 2'd1 || er == 2'd2));
   endtask

   initial begin
      #100000;
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1 reset state
      check(mode_vec == 8'h10, "R1 mode", 32'(mode_vec), 32'h10);
      check(rd_kind == 2'd0 && !bus_oe && !illegal_pulse, "R1 outputs",
            {rd_kind, bus_oe, illegal_pulse}, 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R3 R4 R5 R6 directed decode
      apply(0, 1, 0, 1, 0, 0); check_all("R3 read prog");
      apply(1, 0, 0, 1, 0, 0); check_all("R3 read data");
      apply(0, 1, 1, 0, 0, 0); check_all("R4 load prog");
      apply(1, 0, 1, 0, 0, 0); check_all("R4 load data");
      apply(0, 1, 0, 0, 0, 0); check_all("R5 inhibit");
      apply(1, 0, 1, 1, 0, 0); check_all("R5 out disabled");
      apply(1, 1, 0, 1, 0, 0); check_all("R6 standby");
      // R8 concurrent read, R9 poll, R10 refuse and poll
      apply(0, 1, 0, 1, 0, 1); check_all("R8 prog read, data busy");
      apply(0, 1, 0, 1, 1, 0); check_all("R9 prog read, prog busy");
      apply(1, 0, 0, 1, 1, 0); check_all("R10 data read, prog busy");
      apply(1, 0, 0, 1, 0, 1); check_all("R10 data read, data busy");

      // R7 illegal entry pulse exactly once
      apply(1, 1, 1, 1, 0, 0);
      ill_seen = 0; mon_on = 1'b1;
      apply(0, 0, 0, 1, 0, 0);
      repeat (5) @(negedge clk);
      mon_on = 1'b0;
      check(ill_seen == 1, "R7 pulse count", 32'(ill_seen), 32'd1);
      check_all("R7 illegal");

      // R11 latency
      apply(1, 1, 1, 1, 0, 0);
      @(negedge clk);
      cs_prog_n = 0; oe_n = 0;
      repeat (LAT - 1) @(negedge clk);
      check(mode_vec == 8'h10, "R11 before latency", 32'(mode_vec), 32'h10);
      @(negedge clk);
      check(mode_vec == 8'h01, "R11 at latency", 32'(mode_vec), 32'h01);

      // R11 short write pulse rejected, full-length pulse accepted
      apply(0, 1, 1, 1, 0, 0);
      ld_seen = 0; mon_on = 1'b1;
      we_n = 0;
      repeat (FILT - 1) @(negedge clk);
      we_n = 1;
      repeat (LAT + 4) @(negedge clk);
      check(ld_seen == 0, "R11 short pulse", 32'(ld_seen), 32'd0);
      ld_seen = 0;
      we_n = 0;
      repeat (FILT) @(negedge clk);
      we_n = 1;
      repeat (LAT + 4) @(negedge clk);
      mon_on = 1'b0;
      check(ld_seen > 0, "R11 full pulse", 32'(ld_seen), 32'd1);

      // random held patterns: R2 R3 R4 R5 R6 R7 R8 R9 R10
      for (int k = 0; k < 80; k++) begin
         logic [5:0] r;
         r = 6'($urandom);
         apply(r[0], r[1], r[2], r[3], r[4], r[5]);
         check_all("R2 random");
         check($countones(mode_vec) == 1, "R2 onehot", 32'(mode_vec), 32'h1);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule